// File: doc/BRIEF.md
# Sleep Request/Acknowledge Handshake Controller

This block coordinates entry into and exit from a low-power sleep state for a CAN protocol engine. The engine runs on its own protocol clock, and its registers sit on a separate host clock. Software raises a sleep-request level in the host domain. The controller carries that level across to the protocol domain through a two-flop synchronizer. It then waits until the bus activity allows the engine to stop.

Sleep is entered straight away when the engine is quiet. It is put off while any transmit buffer is still scheduled, and it is put off while a frame is arriving, in which case it waits for the bus to go idle. Once asleep, the controller removes the protocol-side clock enable. It also returns an acknowledge level to the host domain through a second two-flop synchronizer, and software uses that level as the answer to its request. Clearing the request wakes the engine through the same path in reverse.

A module-enable input of the protocol domain overrides all of this: while it is low, the engine is held out of sleep and its clock enable is off.

Top module: `sleep_handshake_ctrl`

## Requirements
- R1: After reset with `mod_en`=1 and the request low, `sleep_active`=0, `proto_clk_en`=1 and `host_sleep_ack`=0.
- R2: With every `tx_empty` bit at 1 (bit i = 1 means buffer i holds nothing to send) and `rx_busy`=0, setting `host_sleep_req` raises `sleep_active` 2 to 4 protocol clock cycles later. Of that delay, two cycles are the request synchronizer and one is the state register.
- R3: Sleep is deferred when any `tx_empty` bit reads 0 in the protocol cycle in which the synchronized request is first seen. `sleep_active` then rises one protocol cycle after the cycle in which all bits read 1.
- R4: If `rx_busy`=1 when the synchronized request is seen, sleep waits until `rx_busy`=0 and `bus_idle`=1. A drop of `rx_busy` alone does not enter sleep. `sleep_active` rises one protocol cycle after `bus_idle` is seen high.
- R5: `proto_clk_en` is 0 whenever `sleep_active` is 1, and it is 1 whenever the block is enabled and awake.
- R6: `host_sleep_ack` follows `sleep_active` through two host-clock flops. It rises within 1 to 3 host cycles after `sleep_active` rises and falls within 1 to 3 host cycles after `sleep_active` falls.
- R7: Clearing `host_sleep_req` while asleep lowers `sleep_active` 2 to 4 protocol cycles later, and `proto_clk_en` returns to 1.
- R8: Clearing the request while sleep is still deferred returns the block to the awake state. Sleep is not entered when the deferring activity ends afterwards.
- R9: While `mod_en`=0, `sleep_active` is 0 and `proto_clk_en` is 0 from the next protocol cycle on, including when sleep was active, and the request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host register clock |
| can_clk | input | 1 | Protocol engine clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| host_sleep_req | input | 1 | Sleep request level, host domain |
| mod_en | input | 1 | Module enable, protocol domain |
| tx_empty | input | NUM_TXBUF | Per-buffer empty flags, 1 = nothing scheduled |
| rx_busy | input | 1 | A frame is being received |
| bus_idle | input | 1 | The bus is idle |
| host_sleep_ack | output | 1 | Sleep acknowledge, host domain |
| sleep_active | output | 1 | Sleep state, protocol domain |
| proto_clk_en | output | 1 | Clock enable for protocol-side logic |

## Verification
Request-driven results cross two synchronizer flops plus the state register. For them the bench counts protocol clock falling edges after the host-side change and accepts the 2 to 4 cycle window that the unknown clock phase allows. Results that follow a protocol-domain input (the last buffer draining, or the bus going idle) are due exactly one protocol cycle later, and those are checked for that exact count. The acknowledge is checked for a 1 to 3 host-cycle window counted from the protocol-side change. Deferral and "no effect" cases are held for ten protocol cycles or more before the outputs are sampled. Inputs are changed, and outputs sampled, on the falling edge of their own clock.

// File: rtl/sleep_hs_pkg.sv
package sleep_hs_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SLEEP = 2'd2
  } sleep_state_e;

  // Nothing scheduled and nothing arriving: sleep may start at once.
  function automatic logic quiet_now(input logic all_empty, input logic rx_busy);
    return all_empty && !rx_busy;
  endfunction

  // Deferred entry completes when buffers are drained and any reception
  // that was seen has been followed by an idle bus.
  function automatic logic drain_done(input logic all_empty, input logic rx_busy,
                                      input logic rx_wait, input logic bus_idle);
    return all_empty && !rx_busy && (!rx_wait || bus_idle);
  endfunction

  // Remember a reception until the bus is seen idle.
  function automatic logic rx_wait_next(input logic rx_wait, input logic rx_busy,
                                        input logic bus_idle);
    return rx_busy || (rx_wait && !bus_idle);
  endfunction

endpackage

// File: rtl/sleep_hs_sync.sv
module sleep_hs_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RESET_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sleep_hs_fsm.sv
module sleep_hs_fsm
  import sleep_hs_pkg::*;
#(
  parameter int NUM_TXBUF = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic                 req_sync,
  input  logic [NUM_TXBUF-1:0] tx_empty,
  input  logic                 rx_busy,
  input  logic                 bus_idle,
  output logic                 sleep_active,
  output logic                 clk_en
);

  sleep_state_e state_q, state_d;
  logic         rx_wait_q, rx_wait_d;
  logic         clk_en_q;
  logic         all_empty;

  assign all_empty = &tx_empty;

  always_comb begin
    state_d   = state_q;
    rx_wait_d = rx_wait_q;
    if (!mod_en) begin
      state_d   = ST_AWAKE;
      rx_wait_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_AWAKE: begin
          if (req_sync) begin
            // Flags are sampled in the very cycle the request arrives.
            if (quiet_now(all_empty, rx_busy)) begin
              state_d = ST_SLEEP;
            end else begin
              state_d   = ST_DRAIN;
              rx_wait_d = rx_busy;
            end
          end
        end
        ST_DRAIN: begin
          if (!req_sync) begin
            state_d   = ST_AWAKE;
            rx_wait_d = 1'b0;
          end else if (drain_done(all_empty, rx_busy, rx_wait_q, bus_idle)) begin
            state_d   = ST_SLEEP;
            rx_wait_d = 1'b0;
          end else begin
            rx_wait_d = rx_wait_next(rx_wait_q, rx_busy, bus_idle);
          end
        end
        ST_SLEEP: begin
          if (!req_sync) state_d = ST_AWAKE;
        end
        default: state_d = ST_AWAKE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_AWAKE;
      rx_wait_q <= 1'b0;
      clk_en_q  <= 1'b1;
    end else begin
      state_q   <= state_d;
      rx_wait_q <= rx_wait_d;
      clk_en_q  <= mod_en && (state_d != ST_SLEEP);
    end
  end

  assign sleep_active = (state_q == ST_SLEEP);
  assign clk_en       = clk_en_q;

endmodule

// File: rtl/sleep_handshake_ctrl.sv
module sleep_handshake_ctrl #(
  parameter int NUM_TXBUF  = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 host_clk,
  input  logic                 can_clk,
  input  logic                 rst_n,
  input  logic                 host_sleep_req,
  input  logic                 mod_en,
  input  logic [NUM_TXBUF-1:0] tx_empty,
  input  logic                 rx_busy,
  input  logic                 bus_idle,
  output logic                 host_sleep_ack,
  output logic                 sleep_active,
  output logic                 proto_clk_en
);

  // Request as seen in the protocol domain (brought out for the checker).
  logic req_sync;

  sleep_hs_sync #(.STAGES(SYNC_DEPTH), .RESET_VAL(1'b0)) u_req_sync (
    .clk   (can_clk),
    .rst_n (rst_n),
    .d     (host_sleep_req),
    .q     (req_sync)
  );

  sleep_hs_fsm #(.NUM_TXBUF(NUM_TXBUF)) u_fsm (
    .clk          (can_clk),
    .rst_n        (rst_n),
    .mod_en       (mod_en),
    .req_sync     (req_sync),
    .tx_empty     (tx_empty),
    .rx_busy      (rx_busy),
    .bus_idle     (bus_idle),
    .sleep_active (sleep_active),
    .clk_en       (proto_clk_en)
  );

  sleep_hs_sync #(.STAGES(SYNC_DEPTH), .RESET_VAL(1'b0)) u_ack_sync (
    .clk   (host_clk),
    .rst_n (rst_n),
    .d     (sleep_active),
    .q     (host_sleep_ack)
  );

endmodule

// File: rtl/sleep_hs_checker.sv
module sleep_hs_checker #(
  parameter int NUM_TXBUF = 3
) (
  input logic                 can_clk,
  input logic                 rst_n,
  input logic                 mod_en,
  input logic                 req_sync,
  input logic [NUM_TXBUF-1:0] tx_empty,
  input logic                 rx_busy,
  input logic                 sleep_active,
  input logic                 proto_clk_en
);

  a_r2_entry_needs_request: assert property (@(posedge can_clk) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(req_sync));

  a_r3_entry_needs_drained_tx: assert property (@(posedge can_clk) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(&tx_empty));

  a_r4_entry_needs_rx_done: assert property (@(posedge can_clk) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(!rx_busy));

  a_r5_clock_gated_in_sleep: assert property (@(posedge can_clk) disable iff (!rst_n)
    sleep_active |-> !proto_clk_en);

  a_r7_leave_on_clear: assert property (@(posedge can_clk) disable iff (!rst_n)
    (sleep_active && !req_sync && mod_en) |=> !sleep_active);

  a_r9_disabled_forces_off: assert property (@(posedge can_clk) disable iff (!rst_n)
    !mod_en |=> (!sleep_active && !proto_clk_en));

endmodule

bind sleep_handshake_ctrl sleep_hs_checker #(.NUM_TXBUF(NUM_TXBUF)) u_sleep_hs_checker (
  .can_clk      (can_clk),
  .rst_n        (rst_n),
  .mod_en       (mod_en),
  .req_sync     (req_sync),
  .tx_empty     (tx_empty),
  .rx_busy      (rx_busy),
  .sleep_active (sleep_active),
  .proto_clk_en (proto_clk_en)
);

// File: tb/test_sleep_handshake_ctrl.sv
`timescale 1ns/1ps
module test_sleep_handshake_ctrl;

  localparam int NTX = 3;

  logic           host_clk = 1'b0;
  logic           can_clk  = 1'b0;
  logic           rst_n    = 1'b0;
  logic           host_sleep_req = 1'b0;
  logic           mod_en   = 1'b1;
  logic [NTX-1:0] tx_empty = '1;
  logic           rx_busy  = 1'b0;
  logic           bus_idle = 1'b1;
  logic           host_sleep_ack;
  logic           sleep_active;
  logic           proto_clk_en;

  int checks = 0;
  int errors = 0;
  int wd_cnt = 0;

  always #10 host_clk = ~host_clk;  // 50 MHz
  always #17 can_clk  = ~can_clk;   // unrelated protocol clock

  sleep_handshake_ctrl #(.NUM_TXBUF(NTX)) i_sleep_handshake_ctrl (
    .host_clk       (host_clk),
    .can_clk        (can_clk),
    .rst_n          (rst_n),
    .host_sleep_req (host_sleep_req),
    .mod_en         (mod_en),
    .tx_empty       (tx_empty),
    .rx_busy        (rx_busy),
    .bus_idle       (bus_idle),
    .host_sleep_ack (host_sleep_ack),
    .sleep_active   (sleep_active),
    .proto_clk_en   (proto_clk_en)
  );

  always @(posedge host_clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", wd_cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic can_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge can_clk);
  endtask

  task automatic wait_sleep(input logic lvl, input int max, output int n);
    n = 0;
    do begin
      @(negedge can_clk);
      n++;
    end while (sleep_active !== lvl && n < max);
  endtask

  task automatic wait_ack(input logic lvl, input int max, output int n);
    n = 0;
    do begin
      @(negedge host_clk);
      n++;
    end while (host_sleep_ack !== lvl && n < max);
  endtask

  task automatic set_req(input logic v);
    @(negedge host_clk);
    host_sleep_req = v;
  endtask

  // Clears the request from sleep and checks R7 and the R6 fall.
  task automatic leave_sleep();
    int n;
    set_req(1'b0);
    wait_sleep(1'b0, 10, n);
    check(sleep_active == 1'b0 && n >= 2 && n <= 4, "R7 sleep exit delay", n, 3);
    @(negedge can_clk);
    check(proto_clk_en == 1'b1, "R7 clock enable back", proto_clk_en, 1);
    wait_ack(1'b0, 10, n);
    check(host_sleep_ack == 1'b0 && n >= 1 && n <= 3, "R6 ack fall delay", n, 2);
  endtask

  task automatic t_reset();
    can_cycles(2);
    check(sleep_active == 1'b0, "R1 sleep after reset", sleep_active, 0);
    check(proto_clk_en == 1'b1, "R1 clk_en after reset", proto_clk_en, 1);
    check(host_sleep_ack == 1'b0, "R1 ack after reset", host_sleep_ack, 0);
  endtask

  task automatic t_immediate();
    int n;
    set_req(1'b1);
    wait_sleep(1'b1, 10, n);
    check(sleep_active == 1'b1 && n >= 2 && n <= 4, "R2 immediate entry delay", n, 3);
    check(proto_clk_en == 1'b0, "R5 clock gated in sleep", proto_clk_en, 0);
    wait_ack(1'b1, 10, n);
    check(host_sleep_ack == 1'b1 && n >= 1 && n <= 3, "R6 ack rise delay", n, 2);
    leave_sleep();
  endtask

  task automatic t_tx_defer();
    int n;
    @(negedge can_clk);
    tx_empty = 3'b101;
    set_req(1'b1);
    can_cycles(12);
    check(sleep_active == 1'b0, "R3 deferred while buffer pending", sleep_active, 0);
    check(proto_clk_en == 1'b1, "R5 clock on while draining", proto_clk_en, 1);
    check(host_sleep_ack == 1'b0, "R3 no ack while pending", host_sleep_ack, 0);
    tx_empty = 3'b111;
    wait_sleep(1'b1, 10, n);
    check(sleep_active == 1'b1 && n == 1, "R3 entry after drain", n, 1);
    wait_ack(1'b1, 10, n);
    check(host_sleep_ack == 1'b1, "R6 ack after tx drain", host_sleep_ack, 1);
    leave_sleep();
  endtask

  task automatic t_rx_defer();
    int n;
    @(negedge can_clk);
    rx_busy  = 1'b1;
    bus_idle = 1'b0;
    set_req(1'b1);
    can_cycles(12);
    check(sleep_active == 1'b0, "R4 deferred while receiving", sleep_active, 0);
    rx_busy = 1'b0;
    can_cycles(5);
    check(sleep_active == 1'b0, "R4 waits for bus idle", sleep_active, 0);
    bus_idle = 1'b1;
    wait_sleep(1'b1, 10, n);
    check(sleep_active == 1'b1 && n == 1, "R4 entry at bus idle", n, 1);
    leave_sleep();
  endtask

  task automatic t_withdraw();
    @(negedge can_clk);
    tx_empty = 3'b011;
    set_req(1'b1);
    can_cycles(10);
    set_req(1'b0);
    can_cycles(8);
    @(negedge can_clk);
    tx_empty = 3'b111;
    can_cycles(8);
    check(sleep_active == 1'b0, "R8 no sleep after withdraw", sleep_active, 0);
    check(proto_clk_en == 1'b1, "R8 clock stays on", proto_clk_en, 1);
    check(host_sleep_ack == 1'b0, "R8 no ack after withdraw", host_sleep_ack, 0);
  endtask

  task automatic t_disable();
    int n;
    set_req(1'b1);
    wait_sleep(1'b1, 10, n);
    check(sleep_active == 1'b1, "R9 setup sleep", sleep_active, 1);
    mod_en = 1'b0;
    @(negedge can_clk);
    check(sleep_active == 1'b0, "R9 disable leaves sleep", sleep_active, 0);
    check(proto_clk_en == 1'b0, "R9 clock off when disabled", proto_clk_en, 0);
    can_cycles(10);
    check(sleep_active == 1'b0, "R9 request ignored when disabled", sleep_active, 0);
    wait_ack(1'b0, 10, n);
    check(host_sleep_ack == 1'b0, "R9 ack clears when disabled", host_sleep_ack, 0);
    set_req(1'b0);
    can_cycles(6);
    mod_en = 1'b1;
    can_cycles(2);
    check(proto_clk_en == 1'b1, "R9 clock back on enable", proto_clk_en, 1);
    check(sleep_active == 1'b0, "R9 awake after enable", sleep_active, 0);
  endtask

  initial begin
    can_cycles(3);
    @(negedge host_clk);
    rst_n = 1'b1;
    t_reset();
    t_immediate();
    t_tx_defer();
    t_rx_defer();
    t_withdraw();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule